// File: doc/BRIEF.md
# Start-Gated Seconds Counter with Multiplexed Display

This block counts seconds in four decimal digits and drives a four-digit, time-multiplexed seven-segment display. A free-running divider turns the fast system clock into a one-cycle enable once per second. The least significant digit advances only on cycles where that enable and the `start` level are both high. Each higher digit advances in the same cycle that every digit below it sits at 9 and is being advanced. The full count therefore runs 0000 to 9999 and then wraps to 0000.

A second divider produces a one-cycle scan enable, at 400 Hz by default. Each scan enable moves a two-bit digit pointer forward. The pointer chooses which digit is shown on the shared segment bus and which digit-select line is pulled low. The display keeps scanning whether or not counting is enabled.

Both divider lengths are parameters. A system can use the real one-second and 400 Hz rates, and a test build can shorten them.

Top module: `start_disp_counter`

## Requirements
- R1: The seconds enable is high for exactly one clock out of every `SEC_TERM+1` clocks, first in the `SEC_TERM+1`-th clock after reset. The count advances by one only at the clock edge where this enable and `start` are both high.
- R2: While `start` is low, the four-digit count keeps its value and the display keeps scanning.
- R3: Each digit holds a value from 0 to 9. A digit that is at 9 and is advanced becomes 0, and the next higher digit advances at the same clock edge.
- R4: When the count is 9999 and it advances, the count becomes 0000.
- R5: The digit pointer advances by one, wrapping from 3 to 0, once every `SCAN_TERM+1` clocks.
- R6: `digit_sel_n` is active-low one-hot: exactly bit k is 0 while the pointer is k.
- R7: `seg_n` shows the digit chosen by the pointer (0 = units, 1 = tens, 2 = hundreds, 3 = thousands).
  - Segments are active-low: bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f, bit 6 = g.
  - Bit 7 (decimal point) is always 1.
  - Digits 0 to 9 light these segments: 0 = abcdef, 1 = bc, 2 = abdeg, 3 = abcdg, 4 = bcfg, 5 = acdfg, 6 = acdefg, 7 = abc, 8 = all seven, 9 = abcdfg.
- R8: A synchronous active-high `rst` clears all digits, both dividers and the pointer. After reset, `digit_sel_n` = 4'b1110 and `seg_n` shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Level that enables counting |
| seg_n | output | 8 | Active-low segments, bit 7 is the decimal point |
| digit_sel_n | output | 4 | Active-low one-hot digit select |

## Verification
The bench builds the block with `SEC_TERM` = 9 and `SCAN_TERM` = 2. The count then steps every 10 clocks and the pointer every 3 clocks. With these values, a run of about 100,000 clocks carries the count through every digit value, every carry pattern and the 9999 to 0000 wrap. Because 3 and 10 share no factor, each digit position is displayed against many different count values.

// File: rtl/disp_cnt_pkg.sv
package disp_cnt_pkg;

   typedef logic [3:0] bcd_t;

   localparam bcd_t BCD_TOP = 4'd9;

   // Active-high pattern {g,f,e,d,c,b,a}. Values above nine give all segments off.
   function automatic logic [6:0] seg_pattern(input bcd_t v);
      logic [6:0] p;
      case (v)
         4'd0:    p = 7'b0111111;
         4'd1:    p = 7'b0000110;
         4'd2:    p = 7'b1011011;
         4'd3:    p = 7'b1001111;
         4'd4:    p = 7'b1100110;
         4'd5:    p = 7'b1101101;
         4'd6:    p = 7'b1111101;
         4'd7:    p = 7'b0000111;
         4'd8:    p = 7'b1111111;
         4'd9:    p = 7'b1101111;
         default: p = 7'b0000000;
      endcase
      return p;
   endfunction

   // Active-low bus with the decimal point held off.
   function automatic logic [7:0] seg_drive_n(input bcd_t v);
      return {1'b1, ~seg_pattern(v)};
   endfunction

endpackage

// File: rtl/pulse_divider.sv
module pulse_divider #(
   parameter int unsigned TERM = 99_999_999
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int unsigned CNT_W = (TERM < 2) ? 1 : $clog2(TERM + 1);
   localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM);

   if (TERM < 1) begin : g_bad_term
      $error("pulse_divider: TERM must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   assign tick = (cnt == TERM_V);

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   // R1
   tick_single_chk: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
   // R8
   div_clear_chk: assert property (@(posedge clk)
      rst |=> (cnt == '0));

endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
   import disp_cnt_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output bcd_t value
);
   always_ff @(posedge clk) begin
      if (rst)
         value <= '0;
      else if (adv)
         value <= (value == BCD_TOP) ? '0 : value + 1'b1;
   end

   // R3
   digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      value <= BCD_TOP);
   // R3
   digit_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (adv && value == BCD_TOP) |=> (value == '0));
   // R2
   digit_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(value));

endmodule

// File: rtl/scan_display.sv
module scan_display
   import disp_cnt_pkg::*;
#(
   parameter int unsigned NUM_DIGITS = 4,
   parameter int unsigned SEL_W      = 2
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        step,
   input  bcd_t [NUM_DIGITS-1:0]       digits,
   output logic [7:0]                  seg_n,
   output logic [NUM_DIGITS-1:0]       sel_n
);
   if ((1 << SEL_W) != NUM_DIGITS) begin : g_bad_sel
      $error("scan_display: NUM_DIGITS must equal 2**SEL_W");
   end

   logic [SEL_W-1:0] ptr;
   bcd_t             shown;

   always_ff @(posedge clk) begin
      if (rst)       ptr <= '0;
      else if (step) ptr <= ptr + 1'b1;
   end

   always_comb begin
      shown = digits[ptr];
      seg_n = seg_drive_n(shown);
   end

   for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_sel
      assign sel_n[k] = (ptr != SEL_W'(k));
   end

   // R6
   sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(~sel_n) == 1);
   // R5
   ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
      step |=> (ptr == SEL_W'($past(ptr) + 1'b1)));
   // R5
   ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(ptr));
   // R7
   dp_off_chk: assert property (@(posedge clk) seg_n[7]);

endmodule

// File: rtl/start_disp_counter.sv
module start_disp_counter
   import disp_cnt_pkg::*;
#(
   parameter int unsigned SEC_TERM   = 99_999_999,
   parameter int unsigned SCAN_TERM  = 249_999,
   parameter int unsigned NUM_DIGITS = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   output logic [7:0] seg_n,
   output logic [3:0] digit_sel_n
);
   localparam int unsigned SEL_W = $clog2(NUM_DIGITS);

   if (NUM_DIGITS != 4) begin : g_bad_digits
      $error("start_disp_counter: the port widths assume four digits");
   end

   logic                  sec_tick;
   logic                  scan_tick;
   logic [NUM_DIGITS-1:0] adv;
   bcd_t [NUM_DIGITS-1:0] digits;

   pulse_divider #(.TERM(SEC_TERM)) u_sec_div (
      .clk (clk),
      .rst (rst),
      .tick(sec_tick)
   );

   pulse_divider #(.TERM(SCAN_TERM)) u_scan_div (
      .clk (clk),
      .rst (rst),
      .tick(scan_tick)
   );

   assign adv[0] = sec_tick & start;

   for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
      bcd_digit u_digit (
         .clk  (clk),
         .rst  (rst),
         .adv  (adv[i]),
         .value(digits[i])
      );
      if (i < NUM_DIGITS - 1) begin : g_carry
         assign adv[i+1] = adv[i] & (digits[i] == BCD_TOP);
      end
   end

   scan_display #(.NUM_DIGITS(NUM_DIGITS), .SEL_W(SEL_W)) u_scan (
      .clk   (clk),
      .rst   (rst),
      .step  (scan_tick),
      .digits(digits),
      .seg_n (seg_n),
      .sel_n (digit_sel_n)
   );

   // R2
   start_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !start |=> $stable(digits));
   // R4
   full_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (adv[0] && digits == {NUM_DIGITS{BCD_TOP}}) |=> (digits == '0));

endmodule

// File: tb/sim_start_disp_counter.sv
module sim_start_disp_counter;
   localparam int CLK_PERIOD = 10;
   localparam int SEC_T      = 9;
   localparam int SCAN_T     = 2;
   localparam int WATCHDOG   = 190_000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [7:0] seg_n;
   logic [3:0] digit_sel_n;

   int    n_vec  = 0;
   int    n_fail = 0;
   int    cycles = 0;
   bit    started = 0;
   bit    done = 0;
   string phase = "R8";

   // reference model state
   int m_sec = 0, m_scan = 0, m_count = 0, m_ptr = 0;

   start_disp_counter #(.SEC_TERM(SEC_T), .SCAN_TERM(SCAN_T)) u0 (
      .clk(clk), .rst(rst), .start(start),
      .seg_n(seg_n), .digit_sel_n(digit_sel_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] exp_seg(input int d);
      logic [6:0] on;
      case (d)
         0: on = 7'b0111111;  1: on = 7'b0000110;
         2: on = 7'b1011011;  3: on = 7'b1001111;
         4: on = 7'b1100110;  5: on = 7'b1101101;
         6: on = 7'b1111101;  7: on = 7'b0000111;
         8: on = 7'b1111111;  default: on = 7'b1101111;
      endcase
      return {1'b1, ~on};
   endfunction

   function automatic int digit_of(input int cnt, input int pos);
      int v = cnt;
      for (int k = 0; k < pos; k++) v = v / 10;
      return v % 10;
   endfunction

   always @(posedge clk) begin
      cycles++;
      started = 1;
      if (rst) begin
         m_sec = 0; m_scan = 0; m_count = 0; m_ptr = 0;
      end else begin
         if (m_sec == SEC_T) begin
            m_sec = 0;
            if (start) m_count = (m_count + 1) % 10000;
         end else m_sec++;
         if (m_scan == SCAN_T) begin
            m_scan = 0;
            m_ptr = (m_ptr + 1) % 4;
         end else m_scan++;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual %b expected %b",
                  req, what, cycles, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started && !done) begin
         check("R5 R6", "digit_sel_n", {4'b0, digit_sel_n},
               {4'b0, ~(4'b0001 << m_ptr)});
         check(phase, "seg_n", seg_n, exp_seg(digit_of(m_count, m_ptr)));
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   endtask

   initial begin
      rst = 1'b1; start = 1'b0; phase = "R8";
      run(4);
      // reset state: pointer 0, count 0 (R8)
      check("R8", "reset digit_sel_n", {4'b0, digit_sel_n}, 8'b0000_1110);
      check("R8", "reset seg_n", seg_n, 8'b1100_0000);
      rst = 1'b0;
      phase = "R2 R7";           // held count, display scanning
      run(400);
      start = 1'b1; phase = "R1 R7";
      run(300);
      phase = "R3 R4 R7";        // carries and 9999 -> 0000
      run(100_300);
      for (int r = 0; r < 20; r++) begin
         start = 1'b0; phase = "R2";
         run(37);
         start = 1'b1; phase = "R1";
         run(53);
      end
      phase = "R8";
      rst = 1'b1;
      run(3);
      rst = 1'b0;
      run(250);
      finish_run();
   end

   initial begin
      wait (cycles >= WATCHDOG);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog expired at cycle %0d: actual running expected finished",
                  cycles);
         finish_run();
      end
   end

endmodule